// File: doc/BRIEF.md
# Serial SLIP Frame Receiver

This block takes an asynchronous 8N1 serial line (nominally 2,766,400 baud) and turns the SLIP-encoded byte stream on it into a stream of payload bytes with frame markers. The first byte of every frame carries a start marker and the last carries an end marker. A level output, `frame_active`, is high while a frame is being received. A downstream high-speed display link transmitter uses this level and the markers to start and stop its burst on the data and clock lanes.

Payload bytes are complete display command packets. Their checksums and error codes were computed by the sender, so the block only removes the framing and never inspects or changes the content. The bit timing comes from a clock divisor parameter: each bit is sampled near its middle by a counter that runs at the system clock.

To mark the last byte of a frame, the block holds one decoded byte back until it knows whether a delimiter follows. Malformed escapes and missing stop bits raise a one-cycle error pulse.

Top module: `slip_uart_rx`

## Requirements
- R1: While reset is high, and after it is released with the line idle high, `out_valid`, `out_sof`, `out_eof`, `frame_active` and `err_flag` are all low.
- R2: A serial byte is one low start bit, then eight data bits least significant bit first, then one high stop bit. Each bit lasts `CLKS_PER_BIT` clock cycles and is sampled at its midpoint.
- R3: A low level on the line is accepted as a start bit only if it is still low half a bit period later. A shorter low pulse produces no byte and no error.
- R4: A byte whose stop bit samples low is discarded and `err_flag` pulses for exactly one cycle. The receiver then waits for the line to return high before it looks for a new start bit.
- R5: The value 0xC0 is the frame delimiter and never appears as a payload byte at the output.
- R6: The escape byte 0xDB followed by 0xDC yields payload byte 0xC0. The escape byte 0xDB followed by 0xDD yields payload byte 0xDB.
- R7: Every completed frame is delivered with `out_sof` on its first output byte and `out_eof` on its last, and on no other byte. A single-byte frame carries both markers on the same beat. The markers are only ever high together with `out_valid`.
- R8: Two delimiters with no payload between them produce no output, no marker and no error.
- R9: An escape byte followed by anything other than 0xDC or 0xDD pulses `err_flag` and aborts the frame. The held byte is dropped, no end marker is sent, and every byte up to the next delimiter is discarded. If the offending byte is itself 0xC0, decoding resumes with the very next byte.
- R10: `frame_active` rises in the cycle after a frame's first payload byte is decoded, with no output beat in that cycle. It stays high for every non-final beat, and falls in the same cycle as the end-marked beat or on an abort.
- R11: Any byte other than 0xC0 or 0xDB, including bare 0xDC and 0xDD, passes to the output unchanged and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| out_valid | output | 1 | One-cycle strobe: a payload byte is on `out_data` |
| out_data | output | 8 | Decoded payload byte |
| out_sof | output | 1 | Beat is the first byte of a frame |
| out_eof | output | 1 | Beat is the last byte of a frame |
| frame_active | output | 1 | High while a frame is in progress |
| err_flag | output | 1 | One-cycle pulse on a bad escape or a missing stop bit |

## Verification
A bit counter or oversampling counter that is off by one shows up at the ports within one serial byte: `out_data` is bit-shifted or corrupted, or `err_flag` pulses on a clean stop bit. A decoder stuck in its escape or discard state shows as missing or mistranslated bytes within one frame. A lost hold-back register shows as a misplaced `out_sof` or `out_eof`, or as `frame_active` staying low while beats flow. That last fault is visible on the very next delimiter.

// File: rtl/slip_rx_pkg.sv
package slip_rx_pkg;

    localparam logic [7:0] FRAME_END  = 8'hC0;
    localparam logic [7:0] FRAME_ESC  = 8'hDB;
    localparam logic [7:0] ESC_OF_END = 8'hDC;
    localparam logic [7:0] ESC_OF_ESC = 8'hDD;

    typedef enum logic [2:0] {
        LINE_IDLE,
        LINE_START,
        LINE_DATA,
        LINE_STOP,
        LINE_BREAK
    } line_state_e;

    typedef enum logic [1:0] {
        DEC_PLAIN,
        DEC_ESCAPED,
        DEC_DISCARD
    } dec_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       sof;
        logic       eof;
    } beat_t;

    function automatic logic is_escape_code(input logic [7:0] b);
        return (b == ESC_OF_END) || (b == ESC_OF_ESC);
    endfunction

    function automatic logic [7:0] unescape(input logic [7:0] b);
        return (b == ESC_OF_END) ? FRAME_END : FRAME_ESC;
    endfunction

endpackage

// File: rtl/slip_line_rx.sv
module slip_line_rx
    import slip_rx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 18,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_i,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       stop_err
);
    localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 2;
    localparam logic [CW-1:0] LAST_TICK = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] HALF_TICK = CW'(CLKS_PER_BIT / 2 - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line;
    line_state_e            st;
    logic [CW-1:0]          tick;
    logic [2:0]             bitn;
    logic [7:0]             shreg;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
    end
    assign line = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= LINE_IDLE;
            tick      <= '0;
            bitn      <= '0;
            shreg     <= '0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
            stop_err  <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            stop_err <= 1'b0;
            case (st)
                LINE_IDLE: begin
                    tick <= '0;
                    if (!line) st <= LINE_START;
                end
                LINE_START: begin
                    if (tick == HALF_TICK) begin
                        tick <= '0;
                        bitn <= '0;
                        st   <= line ? LINE_IDLE : LINE_DATA;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                LINE_DATA: begin
                    if (tick == LAST_TICK) begin
                        tick  <= '0;
                        shreg <= {line, shreg[7:1]};
                        bitn  <= bitn + 1'b1;
                        if (bitn == 3'd7) st <= LINE_STOP;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                LINE_STOP: begin
                    if (tick == LAST_TICK) begin
                        tick <= '0;
                        if (line) begin
                            byte_vld  <= 1'b1;
                            byte_data <= shreg;
                            st        <= LINE_IDLE;
                        end else begin
                            stop_err <= 1'b1;
                            st       <= LINE_BREAK;
                        end
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                LINE_BREAK: begin
                    if (line) st <= LINE_IDLE;
                end
                default: st <= LINE_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/slip_deframe.sv
module slip_deframe
    import slip_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_vld,
    input  logic [7:0] in_byte,
    output logic       beat_vld,
    output beat_t      beat,
    output logic       active,
    output logic       esc_err
);
    dec_state_e st, st_n;
    logic       accept, close, abort;
    logic [7:0] pay;
    logic       hold_vld;
    logic [7:0] hold_data;
    logic       hold_first;

    always_comb begin
        st_n   = st;
        accept = 1'b0;
        close  = 1'b0;
        abort  = 1'b0;
        pay    = in_byte;
        if (in_vld) begin
            case (st)
                DEC_PLAIN: begin
                    if (in_byte == FRAME_END)      close = 1'b1;
                    else if (in_byte == FRAME_ESC) st_n  = DEC_ESCAPED;
                    else                           accept = 1'b1;
                end
                DEC_ESCAPED: begin
                    if (is_escape_code(in_byte)) begin
                        accept = 1'b1;
                        pay    = unescape(in_byte);
                        st_n   = DEC_PLAIN;
                    end else begin
                        abort = 1'b1;
                        st_n  = (in_byte == FRAME_END) ? DEC_PLAIN : DEC_DISCARD;
                    end
                end
                DEC_DISCARD: begin
                    if (in_byte == FRAME_END) st_n = DEC_PLAIN;
                end
                default: st_n = DEC_PLAIN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= DEC_PLAIN;
            hold_vld   <= 1'b0;
            hold_data  <= '0;
            hold_first <= 1'b0;
            beat_vld   <= 1'b0;
            beat       <= '0;
            esc_err    <= 1'b0;
        end else begin
            st       <= st_n;
            beat_vld <= 1'b0;
            beat     <= '0;
            esc_err  <= abort;
            if (accept) begin
                if (hold_vld) begin
                    beat_vld <= 1'b1;
                    beat     <= '{data: hold_data, sof: hold_first, eof: 1'b0};
                end
                hold_vld   <= 1'b1;
                hold_data  <= pay;
                hold_first <= !hold_vld;
            end else if (close && hold_vld) begin
                beat_vld <= 1'b1;
                beat     <= '{data: hold_data, sof: hold_first, eof: 1'b1};
                hold_vld <= 1'b0;
            end else if (abort) begin
                hold_vld <= 1'b0;
            end
        end
    end

    assign active = hold_vld;
endmodule

// File: rtl/slip_uart_rx.sv
module slip_uart_rx
    import slip_rx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 18,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_i,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_sof,
    output logic       out_eof,
    output logic       frame_active,
    output logic       err_flag
);
    logic       rx_vld;
    logic [7:0] rx_byte;
    logic       stop_err;
    logic       esc_err;
    beat_t      beat;

    slip_line_rx #(
        .CLKS_PER_BIT(CLKS_PER_BIT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_line (
        .clk      (clk),
        .rst      (rst),
        .rx_i     (rx_i),
        .byte_vld (rx_vld),
        .byte_data(rx_byte),
        .stop_err (stop_err)
    );

    slip_deframe u_deframe (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (rx_vld),
        .in_byte (rx_byte),
        .beat_vld(out_valid),
        .beat    (beat),
        .active  (frame_active),
        .esc_err (esc_err)
    );

    assign out_data = beat.data;
    assign out_sof  = beat.sof;
    assign out_eof  = beat.eof;
    assign err_flag = stop_err | esc_err;
endmodule

// File: rtl/slip_uart_rx_chk.sv
module slip_uart_rx_chk (
    input logic clk,
    input logic rst,
    input logic out_valid,
    input logic out_sof,
    input logic out_eof,
    input logic frame_active,
    input logic err_flag
);
    assert_markers_need_valid_R7: assert property (@(posedge clk) disable iff (rst)
        (out_sof || out_eof) |-> out_valid);

    assert_eof_ends_frame_R10: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> !frame_active);

    assert_midframe_active_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eof) |-> frame_active);

    assert_first_byte_held_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_active) |-> !out_valid);

    assert_err_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> !err_flag);

    assert_err_no_beat_R9: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> !out_valid);
endmodule

bind slip_uart_rx slip_uart_rx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .out_valid   (out_valid),
    .out_sof     (out_sof),
    .out_eof     (out_eof),
    .frame_active(frame_active),
    .err_flag    (err_flag)
);

// File: tb/sim_slip_uart_rx.sv
`timescale 1ns/1ps
module sim_slip_uart_rx;
    localparam int CPB = 18;
    localparam int NV  = 6;

    // stimulus vectors: encoded input bytes and expected decoded frame
    localparam int          NIN  [NV]    = '{5, 4, 6, 6, 6, 6};
    localparam logic [7:0]  VIN  [NV][8] = '{
        '{8'hC0, 8'h11, 8'h22, 8'h33, 8'hC0, 8'h00, 8'h00, 8'h00},
        '{8'hC0, 8'hDB, 8'hDC, 8'hC0, 8'h00, 8'h00, 8'h00, 8'h00},
        '{8'hC0, 8'h41, 8'hDB, 8'hDD, 8'h42, 8'hC0, 8'h00, 8'h00},
        '{8'hC0, 8'hC0, 8'hC0, 8'h55, 8'h66, 8'hC0, 8'h00, 8'h00},
        '{8'hC0, 8'hDB, 8'hDC, 8'hDB, 8'hDD, 8'hC0, 8'h00, 8'h00},
        '{8'hC0, 8'h00, 8'hFF, 8'hDC, 8'hDD, 8'hC0, 8'h00, 8'h00}
    };
    localparam int          NOUT [NV]    = '{3, 1, 3, 2, 2, 4};
    localparam logic [7:0]  VOUT [NV][8] = '{
        '{8'h11, 8'h22, 8'h33, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        '{8'hC0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        '{8'h41, 8'hDB, 8'h42, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        '{8'h55, 8'h66, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        '{8'hC0, 8'hDB, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        '{8'h00, 8'hFF, 8'hDC, 8'hDD, 8'h00, 8'h00, 8'h00, 8'h00}
    };
    localparam string       VREQ [NV]    = '{"R2 R5 R11", "R6 R7", "R6 R11", "R8", "R6", "R11"};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx  = 1'b1;
    logic       out_valid, out_sof, out_eof, frame_active, err_flag;
    logic [7:0] out_data;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] cap_d [64];
    bit         cap_s [64];
    bit         cap_e [64];
    int         cap_n = 0;
    int         err_n = 0;
    logic [7:0] exp_q [$];

    always #10 clk = ~clk;

    slip_uart_rx #(.CLKS_PER_BIT(CPB)) u0 (
        .clk(clk), .rst(rst), .rx_i(rx),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .frame_active(frame_active), .err_flag(err_flag)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid && cap_n < 64) begin
                cap_d[cap_n] = out_data;
                cap_s[cap_n] = out_sof;
                cap_e[cap_n] = out_eof;
                cap_n = cap_n + 1;
            end
            if (err_flag) err_n = err_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic v);
        rx = v;
        repeat (CPB) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
        send_bit(stop);
        if (!stop) send_bit(1'b1);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic clear_cap();
        cap_n = 0;
        err_n = 0;
        exp_q.delete();
    endtask

    task automatic check_frame(input string req, input int exp_errs);
        chk(cap_n == exp_q.size(), {req, " beat count"}, cap_n, exp_q.size());
        chk(err_n == exp_errs, {req, " error pulses"}, err_n, exp_errs);
        for (int k = 0; k < exp_q.size() && k < cap_n; k++) begin
            chk(cap_d[k] == exp_q[k], {req, " data"}, cap_d[k], exp_q[k]);
            chk(cap_s[k] == (k == 0), {req, " R7 sof"}, cap_s[k], (k == 0));
            chk(cap_e[k] == (k == exp_q.size() - 1), {req, " R7 eof"}, cap_e[k],
                (k == exp_q.size() - 1));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs quiet during reset
        chk({out_valid, out_sof, out_eof, frame_active, err_flag} == 5'b0, "R1 in reset",
            {out_valid, out_sof, out_eof, frame_active, err_flag}, 0);
        rst = 1'b0;
        repeat (3 * CPB) @(negedge clk);
        chk({out_valid, frame_active, err_flag} == 3'b0 && cap_n == 0, "R1 after reset",
            {out_valid, frame_active, err_flag}, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            clear_cap();
            for (int i = 0; i < NIN[v]; i++) send_byte(VIN[v][i], 1'b1);
            settle();
            for (int i = 0; i < NOUT[v]; i++) exp_q.push_back(VOUT[v][i]);
            check_frame(VREQ[v], 0);
        end

        // R10: frame_active while first byte is held back
        clear_cap();
        send_byte(8'hC0, 1'b1);
        send_byte(8'h11, 1'b1);
        settle();
        chk(frame_active == 1'b1, "R10 active after first byte", frame_active, 1);
        chk(cap_n == 0, "R10 first byte held", cap_n, 0);
        send_byte(8'hC0, 1'b1);
        settle();
        chk(frame_active == 1'b0, "R10 inactive after close", frame_active, 0);
        exp_q.push_back(8'h11);
        check_frame("R10 R7 single", 0);

        // R9: bad escape aborts, rest dropped until delimiter
        clear_cap();
        send_byte(8'hC0, 1'b1);
        send_byte(8'hAA, 1'b1);
        send_byte(8'hDB, 1'b1);
        send_byte(8'h41, 1'b1);
        settle();
        chk(frame_active == 1'b0, "R9 abort clears active", frame_active, 0);
        send_byte(8'hBB, 1'b1);
        send_byte(8'hC0, 1'b1);
        settle();
        check_frame("R9 abort", 1);
        clear_cap();
        send_byte(8'h77, 1'b1);
        send_byte(8'hC0, 1'b1);
        settle();
        exp_q.push_back(8'h77);
        check_frame("R9 recovery", 0);

        // R9: escape followed by delimiter resumes immediately
        clear_cap();
        send_byte(8'hC0, 1'b1);
        send_byte(8'hDB, 1'b1);
        send_byte(8'hC0, 1'b1);
        send_byte(8'h55, 1'b1);
        send_byte(8'hC0, 1'b1);
        settle();
        exp_q.push_back(8'h55);
        check_frame("R9 esc-delim", 1);

        // R4: missing stop bit discards the byte
        clear_cap();
        send_byte(8'hC0, 1'b1);
        send_byte(8'h12, 1'b1);
        send_byte(8'h34, 1'b0);
        send_byte(8'h56, 1'b1);
        send_byte(8'hC0, 1'b1);
        settle();
        exp_q.push_back(8'h12);
        exp_q.push_back(8'h56);
        check_frame("R4 stop bit", 1);

        // R3: short low pulse is not a start bit
        clear_cap();
        rx = 1'b0;
        repeat (CPB / 4) @(negedge clk);
        rx = 1'b1;
        repeat (3 * CPB) @(negedge clk);
        chk(cap_n == 0 && err_n == 0 && frame_active == 1'b0, "R3 glitch ignored",
            cap_n + err_n, 0);
        send_byte(8'h5A, 1'b1);
        send_byte(8'hC0, 1'b1);
        settle();
        exp_q.push_back(8'h5A);
        check_frame("R3 after glitch", 0);

        // R7: long frame, markers only at the ends
        clear_cap();
        send_byte(8'hC0, 1'b1);
        for (int i = 1; i <= 20; i++) begin
            send_byte(8'(i * 3), 1'b1);
            exp_q.push_back(8'(i * 3));
        end
        send_byte(8'hC0, 1'b1);
        settle();
        check_frame("R7 R11 long", 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule